// File: doc/BRIEF.md
# Memory Chip-Enable Gate with Power-Fail Protection

This block sits between a host's active-low chip-enable and the chip-enable pin of an external memory that shares its address window with a hidden clock access engine. While the supply is healthy and the clock engine is idle, the memory enable simply follows the host enable. The memory therefore still sees every access made before the engine recognises its unlock pattern.

When the engine reports that a clock data transfer is under way, the memory enable is held inactive so that the memory stays off the bus. When the synchronized power-fail flag is set, the enable is forced to a safe level chosen by a mode strap. In RAM mode it is held inactive (high) to write-protect the RAM. In ROM mode it is driven low.

On the rising edge of power failure the block sends the access engine a one-cycle abort. For as long as the flag stays set, it also holds an inhibit level that blocks new clock access. The output enable is registered, so every forcing decision takes effect on the cycle after its inputs are sampled.

Top module: `memgate_ctrl`

## Requirements
- R1: While rst_n is low at a rising clock edge, after that edge mem_ce_n is 1, eng_abort is 0 and eng_inhibit is 0, whatever the other inputs are.
- R2: With pwr_fail = 0 and xfer_busy = 0 sampled at an edge, mem_ce_n after that edge equals the host_ce_n sampled at that edge.
- R3: With pwr_fail = 0 and xfer_busy = 1 sampled at an edge, mem_ce_n is 1 after that edge, for either value of host_ce_n.
- R4: With pwr_fail = 1 and rom_mode = 0 (RAM mode) sampled at an edge, mem_ce_n is 1 after that edge, for any host_ce_n.
- R5: With pwr_fail = 1 and rom_mode = 1 (ROM mode) sampled at an edge, mem_ce_n is 0 after that edge, for any host_ce_n.
- R6: eng_abort is 1 for exactly one cycle, after the first edge at which pwr_fail is sampled 1 following an edge where it was sampled 0 (or following reset). It is 0 otherwise, including while the flag stays high and when it falls.
- R7: After each edge out of reset, eng_inhibit equals the pwr_fail value sampled at that edge.
- R8: Power failure takes precedence over a transfer in progress: with pwr_fail = 1 and xfer_busy = 1, mem_ce_n follows R4/R5 and not R3.
- R9: At the first edge where pwr_fail is sampled 0 again after failure, with xfer_busy = 0, mem_ce_n returns to following host_ce_n, eng_inhibit drops and no abort is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_ce_n | input | 1 | Host chip-enable, active low |
| pwr_fail | input | 1 | Synchronized power-fail flag, 1 = supply below trip point |
| rom_mode | input | 1 | Mode strap: 1 = ROM, 0 = RAM |
| xfer_busy | input | 1 | Clock access engine is moving data |
| mem_ce_n | output | 1 | Registered chip-enable to the external memory, active low |
| eng_abort | output | 1 | One-cycle abort to the clock access engine |
| eng_inhibit | output | 1 | Blocks new clock access while power is failing |

## Verification
A wrong gating choice shows at mem_ce_n on the very next cycle. A swapped ROM/RAM level, a missing transfer mask or a lost priority of power failure over busy each give the opposite enable level, one cycle after the inputs that select it. A stuck edge-history register shows as an abort that never fires, repeats while the flag stays high, or fires on the falling edge. A stale inhibit lags or leads the flag by one cycle. Each of these is visible within one or two cycles of the pwr_fail transition that exposes it.

// File: rtl/memgate_pkg.sv
// Shared types for the memory chip-enable gate.
// Assumes: all enables are active low; the power-fail flag is already synchronous.
package memgate_pkg;

    // Which rule drives the memory enable in a given cycle.
    typedef enum logic [1:0] {
        GATE_PASS        = 2'd0,
        GATE_XFER_MASK   = 2'd1,
        GATE_RAM_PROTECT = 2'd2,
        GATE_ROM_DRIVE   = 2'd3
    } gate_sel_e;

    // Enable level that a forcing rule imposes; PASS returns the host level.
    function automatic logic gate_level(input gate_sel_e sel, input logic host_n);
        case (sel)
            GATE_PASS:        gate_level = host_n;
            GATE_XFER_MASK:   gate_level = 1'b1;
            GATE_RAM_PROTECT: gate_level = 1'b1;
            default:          gate_level = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/memgate_pf_track.sv
// Power-fail tracker: produces a one-cycle abort on the rising edge of the
// flag and a registered inhibit level that mirrors the flag.
// Assumes: pf_i is synchronous to clk; reset treats the flag as previously low.
module memgate_pf_track (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_i,
    output logic abort_o,
    output logic inhibit_o
);

    logic pf_seen_q;
    logic abort_q;

    // Record the sampled flag and raise abort only on a 0 -> 1 change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_seen_q <= 1'b0;
            abort_q   <= 1'b0;
        end else begin
            pf_seen_q <= pf_i;
            abort_q   <= pf_i & ~pf_seen_q;
        end
    end

    assign abort_o   = abort_q;
    assign inhibit_o = pf_seen_q;

endmodule

// File: rtl/memgate_sel.sv
// Gating rule selector: decides which rule owns the memory enable.
// Priority: power failure (level by mode strap) over transfer mask over pass.
// Assumes: all inputs are sampled in the clk domain of the output stage.
module memgate_sel
    import memgate_pkg::*;
(
    input  logic      pf_i,
    input  logic      rom_i,
    input  logic      busy_i,
    output gate_sel_e sel_o
);

    // Pick the forcing rule for this cycle.
    always_comb begin
        if (pf_i)
            sel_o = rom_i ? GATE_ROM_DRIVE : GATE_RAM_PROTECT;
        else if (busy_i)
            sel_o = GATE_XFER_MASK;
        else
            sel_o = GATE_PASS;
    end

endmodule

// File: rtl/memgate_out.sv
// Output register for the memory chip-enable.
// Assumes: sel_i and host_n_i are valid at each rising clk edge.
module memgate_out
    import memgate_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  gate_sel_e sel_i,
    input  logic      host_n_i,
    output logic      ce_n_o
);

    // Register the level chosen by the active rule; idle while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ce_n_o <= IDLE_LEVEL;
        else
            ce_n_o <= gate_level(sel_i, host_n_i);
    end

endmodule

// File: rtl/memgate_ctrl.sv
// Memory chip-enable gate: passes the host enable to the memory, masks it
// during clock transfers, forces a mode-dependent safe level on power
// failure, and tells the clock access engine to abort and hold off.
// Assumes: pwr_fail is synchronized; one-cycle registered latency is acceptable.
module memgate_ctrl
    import memgate_pkg::*;
#(
    parameter logic CE_IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_ce_n,
    input  logic pwr_fail,
    input  logic rom_mode,
    input  logic xfer_busy,
    output logic mem_ce_n,
    output logic eng_abort,
    output logic eng_inhibit
);

    gate_sel_e sel;

    memgate_sel u_sel (
        .pf_i   (pwr_fail),
        .rom_i  (rom_mode),
        .busy_i (xfer_busy),
        .sel_o  (sel)
    );

    memgate_out #(.IDLE_LEVEL(CE_IDLE_LEVEL)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel),
        .host_n_i (host_ce_n),
        .ce_n_o   (mem_ce_n)
    );

    memgate_pf_track u_pf (
        .clk       (clk),
        .rst_n     (rst_n),
        .pf_i      (pwr_fail),
        .abort_o   (eng_abort),
        .inhibit_o (eng_inhibit)
    );

endmodule

// File: rtl/memgate_ctrl_chk.sv
// Checker for memgate_ctrl, attached by bind. Relates outputs to inputs
// sampled one edge earlier; armed only once that edge was out of reset.
module memgate_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic host_ce_n,
    input logic pwr_fail,
    input logic rom_mode,
    input logic xfer_busy,
    input logic mem_ce_n,
    input logic eng_abort,
    input logic eng_inhibit
);

    logic armed;

    // Set once the previous edge was a non-reset edge.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2
    ce_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(pwr_fail) && !$past(xfer_busy) |-> mem_ce_n == $past(host_ce_n));

    // R3
    ce_xfer_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(pwr_fail) && $past(xfer_busy) |-> mem_ce_n);

    // R4
    ram_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(pwr_fail) && !$past(rom_mode) |-> mem_ce_n);

    // R5
    rom_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(pwr_fail) && $past(rom_mode) |-> !mem_ce_n);

    // R6
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |=> !eng_abort);

    // R6
    abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && eng_abort |-> $past(pwr_fail) && eng_inhibit);

    // R7
    inhibit_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> eng_inhibit == $past(pwr_fail));

endmodule

bind memgate_ctrl memgate_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ce_n   (host_ce_n),
    .pwr_fail    (pwr_fail),
    .rom_mode    (rom_mode),
    .xfer_busy   (xfer_busy),
    .mem_ce_n    (mem_ce_n),
    .eng_abort   (eng_abort),
    .eng_inhibit (eng_inhibit)
);

// File: tb/sim_memgate_ctrl.sv
module sim_memgate_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_ce_n = 1'b1;
    logic pwr_fail = 1'b0;
    logic rom_mode = 1'b0;
    logic xfer_busy = 1'b0;
    logic mem_ce_n, eng_abort, eng_inhibit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic  ce;
        logic  ab;
        logic  inh;
        string ce_tag;
        string ab_tag;
    } exp_t;

    exp_t exp_q[$];
    logic model_pf_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memgate_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .host_ce_n(host_ce_n), .pwr_fail(pwr_fail),
        .rom_mode(rom_mode), .xfer_busy(xfer_busy), .mem_ce_n(mem_ce_n),
        .eng_abort(eng_abort), .eng_inhibit(eng_inhibit)
    );

    task automatic check1(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Driver: apply inputs at falling edge, queue what the next rising edge yields.
    task automatic drive(input logic h, input logic pf, input logic rom, input logic busy);
        exp_t e;
        @(negedge clk);
        host_ce_n = h; pwr_fail = pf; rom_mode = rom; xfer_busy = busy;
        if (pf) begin
            e.ce = ~rom;
            e.ce_tag = busy ? "R8" : (rom ? "R5" : "R4");
        end else if (busy) begin
            e.ce = 1'b1; e.ce_tag = "R3";
        end else begin
            e.ce = h; e.ce_tag = model_pf_prev ? "R9" : "R2";
        end
        e.ab  = pf & ~model_pf_prev;
        e.inh = pf;
        e.ab_tag = (!pf && model_pf_prev) ? "R9" : "R6";
        model_pf_prev = pf;
        exp_q.push_back(e);
    endtask

    // Monitor: after each rising edge, compare outputs with the queued item.
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check1(e.ce_tag, mem_ce_n, e.ce, "mem_ce_n");
            check1(e.ab_tag, eng_abort, e.ab, "eng_abort");
            check1("R7", eng_inhibit, e.inh, "eng_inhibit");
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset dominates even with forcing inputs active.
        @(negedge clk);
        host_ce_n = 1'b0; pwr_fail = 1'b1; rom_mode = 1'b1; xfer_busy = 1'b1;
        @(posedge clk); #1;
        check1("R1", mem_ce_n, 1'b1, "mem_ce_n");
        check1("R1", eng_abort, 1'b0, "eng_abort");
        check1("R1", eng_inhibit, 1'b0, "eng_inhibit");
        @(negedge clk);
        host_ce_n = 1'b1; pwr_fail = 1'b0; rom_mode = 1'b0; xfer_busy = 1'b0;
        rst_n = 1'b1;
        model_pf_prev = 1'b0;

        // R2: pass-through with a toggling host enable.
        drive(0, 0, 0, 0); drive(1, 0, 0, 0); drive(0, 0, 0, 0); drive(0, 0, 1, 0);
        drive(1, 0, 1, 0);
        // R3: transfer masks the memory regardless of host level.
        drive(0, 0, 0, 1); drive(1, 0, 0, 1); drive(0, 0, 1, 1); drive(0, 0, 0, 0);
        // R4, R6, R7: RAM mode failure, held for several cycles.
        drive(0, 1, 0, 0); drive(0, 1, 0, 0); drive(1, 1, 0, 0); drive(0, 1, 0, 1);
        // R9: recovery to pass-through, no abort on falling flag.
        drive(0, 0, 0, 0); drive(1, 0, 0, 0);
        // R5: ROM mode failure drives low.
        drive(1, 1, 1, 0); drive(1, 1, 1, 0); drive(0, 1, 1, 0);
        // R8: failure with a transfer in progress, both modes.
        drive(1, 1, 1, 1); drive(0, 0, 0, 1); drive(0, 1, 0, 1); drive(0, 0, 0, 0);
        // R6: single-cycle flag pulses re-arm the abort.
        drive(1, 1, 0, 0); drive(1, 0, 0, 0); drive(1, 1, 1, 0); drive(0, 0, 1, 0);
        drive(1, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule